// File: doc/BRIEF.md
# Readout Handshake Sequencer

This block runs the per-event readout conversation between a card's readout interface and the trigger master. While idle it waits for the start-readout input to rise. It then raises readout-enable. While readout-enable is high, it passes each offered data word into a FIFO write port. When the done (last-pass) indication arrives, it drops readout-enable and drives an active-low end-of-event reset pulse. The pulse is sent either at once, or only after the external readout has also finished; a control input picks which. The block then returns to idle.

Alongside the sequence, a watchdog times the gap between a validation and its acknowledge. It counts one system clock of 62.5 ns per step, so a limit of 1600 gives 100 us. If the acknowledge does not come in time, it sets a sticky status bit. Control inputs select a software test mode, enable the watchdog, bypass the card entirely, and choose when the end-of-event reset is issued.

The data path uses valid/ready on both sides. A word moves only in a cycle where the source's `word_valid_i` and the FIFO's `fifo_ready_i` are both high during a transfer. `word_ready_o` is the acknowledge back to the source. It stays low while the FIFO is full, so the source must hold its word stable until it sees the acknowledge. The FIFO side must not take a word unless `fifo_valid_o` is high.

Top module: `rdo_handshake_seq`

## Requirements
- R1: After reset, `rden_o` is 0, `eoe_rst_n_o` is 1, `word_ready_o` and `fifo_valid_o` are 0 and `tmo_flag_o` is 0.
- R2: In idle, with test mode and bypass off, a rising edge of `start_i` makes `rden_o` 1 from the clock edge that first samples `start_i` high. A level that stays high does not start a second readout.
- R3: While `rden_o` is 1, `fifo_valid_o` follows `word_valid_i` and `fifo_data_o` follows `word_i` in the same cycle. `word_ready_o` is 1 only when `fifo_ready_i` is 1, so the acknowledge is withheld while the FIFO is full.
- R4: While `rden_o` is 0, `word_ready_o` and `fifo_valid_o` stay 0 whatever the data inputs do.
- R5: With `cfg_eoe_at_ext_i` = 0, the edge that samples the done request clears `rden_o` and drives `eoe_rst_n_o` low. It stays low for exactly `EOE_CYCLES` (default 2) cycles, and then the block is idle.
- R6: With `cfg_eoe_at_ext_i` = 1, the done request clears `rden_o` but leaves `eoe_rst_n_o` high until `ext_done_i` is sampled high. The low pulse of `EOE_CYCLES` cycles then starts on that edge.
- R7: With `cfg_test_i` = 1, `start_i` and `lastpass_i` are ignored. `sw_rden_i` starts a readout and `sw_lastpass_i` ends it, each acting on the edge that samples it high.
- R8: With `cfg_bypass_i` = 1, no readout starts from idle, so `rden_o` stays 0.
- R9: A rising edge of `val_i` clears `tmo_flag_o` and restarts the count. If `cfg_tmo_en_i` is 1, `cfg_tmo_limit_i` is L > 0, and `valack_i` stays low, then `tmo_flag_o` becomes 1 on the L-th edge after the edge that sampled the rise, and stays 1.
- R10: A `valack_i` sampled on or before that L-th edge prevents the flag, and so does the same-cycle case. A limit of 0 or `cfg_tmo_en_i` = 0 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (62.5 ns period) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_test_i | input | 1 | 1 = software test mode |
| cfg_tmo_en_i | input | 1 | 1 = acknowledge watchdog enabled |
| cfg_bypass_i | input | 1 | 1 = card bypassed, no readout |
| cfg_eoe_at_ext_i | input | 1 | 1 = end-of-event reset after external readout, 0 = after internal transfer |
| cfg_tmo_limit_i | input | TMO_W | Watchdog limit in clock cycles, 0 = off |
| val_i | input | 1 | Validation |
| valack_i | input | 1 | Validation acknowledge |
| start_i | input | 1 | Start-readout request (rising edge) |
| lastpass_i | input | 1 | Active-high done at end of internal transfer |
| ext_done_i | input | 1 | External readout finished |
| sw_rden_i | input | 1 | Test-mode software readout-enable request |
| sw_lastpass_i | input | 1 | Test-mode software done request |
| word_valid_i | input | 1 | Data-ready from the source |
| word_i | input | DATA_W | Data word |
| word_ready_o | output | 1 | Acknowledge to the source |
| fifo_valid_o | output | 1 | FIFO write valid |
| fifo_data_o | output | DATA_W | FIFO write data |
| fifo_ready_i | input | 1 | FIFO has space |
| rden_o | output | 1 | Readout enable |
| eoe_rst_n_o | output | 1 | Active-low end-of-event reset |
| tmo_flag_o | output | 1 | Watchdog expired (sticky until next validation) |

## Verification
Two things can land on the same clock edge: an acknowledge arriving and the watchdog reaching its limit. A table of timing vectors places `valack_i` exactly on the edge where the count reaches the limit, one edge later, and earlier. The flag must stay clear in the same-edge case and must be set when the acknowledge is one edge late. A second same-cycle case checks back-pressure. The FIFO's ready is dropped while a word is offered, and the acknowledge must fall in that very cycle while `fifo_valid_o` stays high.

// File: rtl/rdo_seq_pkg.sv
package rdo_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_XFER     = 2'd1,
    ST_WAIT_EXT = 2'd2,
    ST_EOE      = 2'd3
  } seq_state_e;

  localparam int unsigned EDGE_START = 0;
  localparam int unsigned EDGE_VAL   = 1;
  localparam int unsigned EDGE_NUM   = 2;
endpackage

// File: rtl/rdo_edge_det.sv
module rdo_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/rdo_ack_watchdog.sv
module rdo_ack_watchdog #(
  parameter int unsigned TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             val_rise_i,
  input  logic             valack_i,
  input  logic             en_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             flag_o
);
  logic             armed_q;
  logic [TMO_W-1:0] cnt_q;
  logic             live;
  logic             hit;

  assign live = en_i && (limit_i != '0);
  assign hit  = live && ((cnt_q + TMO_W'(1)) == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      flag_o  <= 1'b0;
    end else if (val_rise_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      flag_o  <= 1'b0;
    end else if (armed_q) begin
      if (valack_i) begin
        armed_q <= 1'b0;
      end else if (hit) begin
        armed_q <= 1'b0;
        flag_o  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + TMO_W'(1);
      end
    end
  end
endmodule

// File: rtl/rdo_word_gate.sv
module rdo_word_gate #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              active_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              word_ready_o,
  output logic              fifo_valid_o,
  output logic [DATA_W-1:0] fifo_data_o,
  input  logic              fifo_ready_i
);
  assign fifo_valid_o = active_i & word_valid_i;
  assign word_ready_o = active_i & fifo_ready_i;
  assign fifo_data_o  = word_i;
endmodule

// File: rtl/rdo_handshake_seq.sv
module rdo_handshake_seq
  import rdo_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned TMO_W      = 32,
  parameter int unsigned EOE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_test_i,
  input  logic              cfg_tmo_en_i,
  input  logic              cfg_bypass_i,
  input  logic              cfg_eoe_at_ext_i,
  input  logic [TMO_W-1:0]  cfg_tmo_limit_i,
  input  logic              val_i,
  input  logic              valack_i,
  input  logic              start_i,
  input  logic              lastpass_i,
  input  logic              ext_done_i,
  input  logic              sw_rden_i,
  input  logic              sw_lastpass_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              word_ready_o,
  output logic              fifo_valid_o,
  output logic [DATA_W-1:0] fifo_data_o,
  input  logic              fifo_ready_i,
  output logic              rden_o,
  output logic              eoe_rst_n_o,
  output logic              tmo_flag_o
);
  localparam int unsigned EC_W = $clog2(EOE_CYCLES + 1);

  seq_state_e          state_q, state_d;
  logic [EC_W-1:0]     eoe_cnt_q, eoe_cnt_d;
  logic [EDGE_NUM-1:0] lvl, rise;
  logic                go_req, done_req;

  assign lvl[EDGE_START] = start_i;
  assign lvl[EDGE_VAL]   = val_i;

  rdo_edge_det #(.N(EDGE_NUM)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  rdo_ack_watchdog #(.TMO_W(TMO_W)) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .val_rise_i (rise[EDGE_VAL]),
    .valack_i   (valack_i),
    .en_i       (cfg_tmo_en_i),
    .limit_i    (cfg_tmo_limit_i),
    .flag_o     (tmo_flag_o)
  );

  assign go_req   = cfg_test_i ? sw_rden_i     : rise[EDGE_START];
  assign done_req = cfg_test_i ? sw_lastpass_i : lastpass_i;

  always_comb begin
    state_d   = state_q;
    eoe_cnt_d = eoe_cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!cfg_bypass_i && go_req) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (done_req) begin
          eoe_cnt_d = '0;
          state_d   = cfg_eoe_at_ext_i ? ST_WAIT_EXT : ST_EOE;
        end
      end
      ST_WAIT_EXT: begin
        if (ext_done_i) begin
          eoe_cnt_d = '0;
          state_d   = ST_EOE;
        end
      end
      ST_EOE: begin
        if (eoe_cnt_q == EC_W'(EOE_CYCLES - 1)) state_d = ST_IDLE;
        else eoe_cnt_d = eoe_cnt_q + EC_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      eoe_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      eoe_cnt_q <= eoe_cnt_d;
    end
  end

  assign rden_o      = (state_q == ST_XFER);
  assign eoe_rst_n_o = (state_q != ST_EOE);

  rdo_word_gate #(.DATA_W(DATA_W)) u_gate (
    .active_i     (rden_o),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .word_ready_o (word_ready_o),
    .fifo_valid_o (fifo_valid_o),
    .fifo_data_o  (fifo_data_o),
    .fifo_ready_i (fifo_ready_i)
  );
endmodule

// File: rtl/rdo_handshake_seq_chk.sv
module rdo_handshake_seq_chk #(
  parameter int unsigned TMO_W      = 32,
  parameter int unsigned EOE_CYCLES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_bypass_i,
  input logic             cfg_tmo_en_i,
  input logic [TMO_W-1:0] cfg_tmo_limit_i,
  input logic             fifo_ready_i,
  input logic             word_ready_o,
  input logic             fifo_valid_o,
  input logic             rden_o,
  input logic             eoe_rst_n_o,
  input logic             tmo_flag_o
);
  localparam int unsigned LC_W = $clog2(EOE_CYCLES + 2) + 1;
  logic [LC_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (!eoe_rst_n_o)     low_cnt <= low_cnt + LC_W'(1);
    else                       low_cnt <= '0;
  end

  // R5: pulse never longer than EOE_CYCLES
  p_eoe_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= LC_W'(EOE_CYCLES));
  // R5: pulse ends exactly after EOE_CYCLES
  p_eoe_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoe_rst_n_o) |-> ($past(low_cnt) == LC_W'(EOE_CYCLES - 1)));
  // R5: no readout enable during end-of-event reset
  p_eoe_no_rden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eoe_rst_n_o |-> !rden_o);
  // R3: a FIFO push is always acknowledged to the source
  p_push_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid_o && fifo_ready_i) |-> word_ready_o);
  // R4: quiet data path outside transfer
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rden_o |-> (!word_ready_o && !fifo_valid_o));
  // R8: bypass holds the block out of readout
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass_i && !rden_o) |=> !rden_o);
  // R10: flag only rises when the watchdog was live
  p_tmo_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag_o) |-> ($past(cfg_tmo_en_i) && ($past(cfg_tmo_limit_i) != '0)));
endmodule

bind rdo_handshake_seq rdo_handshake_seq_chk #(
  .TMO_W(TMO_W), .EOE_CYCLES(EOE_CYCLES)
) u_chk (.*);

// File: tb/rdo_handshake_seq_tb_top.sv
module rdo_handshake_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int TW = 32;

  typedef struct packed {
    logic [7:0] limit;
    logic       en;
    logic [7:0] ack_at;
    logic [7:0] chk_at;
    logic       exp;
  } tmo_vec_t;

  localparam int NV = 8;
  localparam tmo_vec_t VEC [NV] = '{
    '{limit: 8'd3, en: 1'b1, ack_at: 8'd0, chk_at: 8'd3, exp: 1'b1},
    '{limit: 8'd3, en: 1'b1, ack_at: 8'd0, chk_at: 8'd2, exp: 1'b0},
    '{limit: 8'd3, en: 1'b1, ack_at: 8'd3, chk_at: 8'd5, exp: 1'b0},
    '{limit: 8'd3, en: 1'b1, ack_at: 8'd4, chk_at: 8'd5, exp: 1'b1},
    '{limit: 8'd0, en: 1'b1, ack_at: 8'd0, chk_at: 8'd6, exp: 1'b0},
    '{limit: 8'd4, en: 1'b0, ack_at: 8'd0, chk_at: 8'd8, exp: 1'b0},
    '{limit: 8'd5, en: 1'b1, ack_at: 8'd2, chk_at: 8'd9, exp: 1'b0},
    '{limit: 8'd1, en: 1'b1, ack_at: 8'd0, chk_at: 8'd1, exp: 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_test = 0, cfg_tmo_en = 0, cfg_bypass = 0, cfg_eoe_at_ext = 0;
  logic [TW-1:0] cfg_tmo_limit = '0;
  logic val = 0, valack = 0, start = 0, lastpass = 0, ext_done = 0;
  logic sw_rden = 0, sw_lastpass = 0, word_valid = 0, fifo_ready = 0;
  logic [DW-1:0] word = '0;
  logic word_ready, fifo_valid, rden, eoe_rst_n, tmo_flag;
  logic [DW-1:0] fifo_data;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdo_handshake_seq #(.DATA_W(DW), .TMO_W(TW), .EOE_CYCLES(2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_test_i(cfg_test), .cfg_tmo_en_i(cfg_tmo_en), .cfg_bypass_i(cfg_bypass),
    .cfg_eoe_at_ext_i(cfg_eoe_at_ext), .cfg_tmo_limit_i(cfg_tmo_limit),
    .val_i(val), .valack_i(valack), .start_i(start), .lastpass_i(lastpass),
    .ext_done_i(ext_done), .sw_rden_i(sw_rden), .sw_lastpass_i(sw_lastpass),
    .word_valid_i(word_valid), .word_i(word), .word_ready_o(word_ready),
    .fifo_valid_o(fifo_valid), .fifo_data_o(fifo_data), .fifo_ready_i(fifo_ready),
    .rden_o(rden), .eoe_rst_n_o(eoe_rst_n), .tmo_flag_o(tmo_flag)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 rden", rden, 0); chk("R1 eoe", eoe_rst_n, 1);
    chk("R1 ack", word_ready, 0); chk("R1 fvalid", fifo_valid, 0);
    chk("R1 flag", tmo_flag, 0);
    rst_n = 1; tick();

    // watchdog vector table (R9, R10)
    for (int i = 0; i < NV; i++) begin
      cfg_tmo_limit = TW'(VEC[i].limit); cfg_tmo_en = VEC[i].en;
      val = 0; valack = 0; tick();
      val = 1; tick();
      for (int c = 1; c <= int'(VEC[i].chk_at); c++) begin
        valack = (c == int'(VEC[i].ack_at));
        tick();
      end
      valack = 0;
      chk(VEC[i].exp ? "R9 expiry" : "R10 no expiry", tmo_flag, VEC[i].exp);
    end

    // R9 restart on new validation
    cfg_tmo_en = 1; cfg_tmo_limit = 4;
    val = 0; tick(); val = 1; tick();
    chk("R9 cleared by rise", tmo_flag, 0);
    tick(); tick(); val = 0; tick(); val = 1; tick();
    tick(); tick(); tick();
    chk("R9 restart not yet", tmo_flag, 0);
    tick();
    chk("R9 restart expiry", tmo_flag, 1);
    val = 0; cfg_tmo_en = 0;

    // R2 start edge, R3 data path
    start = 1; tick();
    chk("R2 rden on edge", rden, 1);
    word_valid = 1; word = 32'hA5A5_0001; fifo_ready = 1; #1;
    chk("R3 fvalid", fifo_valid, 1); chk("R3 data", fifo_data, 32'hA5A5_0001);
    chk("R3 ack", word_ready, 1);
    fifo_ready = 0; #1;
    chk("R3 backpressure ack", word_ready, 0); chk("R3 fvalid held", fifo_valid, 1);
    tick(); fifo_ready = 1;
    // R5 internal end
    lastpass = 1; tick(); lastpass = 0;
    chk("R5 rden drop", rden, 0); chk("R5 eoe low1", eoe_rst_n, 0);
    chk("R4 ack idle", word_ready, 0); chk("R4 fvalid idle", fifo_valid, 0);
    tick(); chk("R5 eoe low2", eoe_rst_n, 0);
    tick(); chk("R5 eoe high", eoe_rst_n, 1);
    tick(); chk("R2 level no restart", rden, 0);
    word_valid = 0; fifo_ready = 0;

    // R6 external end
    cfg_eoe_at_ext = 1; start = 0; tick(); start = 1; tick();
    chk("R6 rden", rden, 1);
    lastpass = 1; tick(); lastpass = 0;
    chk("R6 rden drop", rden, 0); chk("R6 eoe wait", eoe_rst_n, 1);
    tick(); chk("R6 eoe still wait", eoe_rst_n, 1);
    ext_done = 1; tick(); ext_done = 0;
    chk("R6 eoe low1", eoe_rst_n, 0);
    tick(); chk("R6 eoe low2", eoe_rst_n, 0);
    tick(); chk("R6 eoe high", eoe_rst_n, 1);

    // R7 test mode
    cfg_eoe_at_ext = 0; cfg_test = 1; start = 0; tick(); start = 1; tick();
    chk("R7 start ignored", rden, 0);
    sw_rden = 1; tick(); sw_rden = 0;
    chk("R7 sw rden", rden, 1);
    lastpass = 1; tick(); lastpass = 0;
    chk("R7 lastpass ignored", rden, 1);
    sw_lastpass = 1; tick(); sw_lastpass = 0;
    chk("R7 sw lastpass", eoe_rst_n, 0);
    tick(); tick();
    chk("R7 back idle", eoe_rst_n, 1);

    // R8 bypass
    cfg_test = 0; cfg_bypass = 1; start = 0; tick(); start = 1; tick();
    chk("R8 bypass start", rden, 0);
    tick(); chk("R8 bypass stays", rden, 0);
    start = 0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule